// File: doc/BRIEF.md
# Fault Recovery Retry Sequencer

This block supervises a power output stage that flags trouble on an active-low fault line, raised for over-current or over-temperature. When the line reads low and the block is not bypassed, it pulls its active-low tri-state/recovery output to 0. A low on that output tells the power stage to begin recovery. The output stays low for a programmed hold time and is then released to 1. After one tick of settling, the block samples the fault line again. It keeps pulsing for as long as the fault persists.

The hold time is a 16-bit recovery constant counted in prescaled ticks of `PRESCALE` clock cycles. The default prescale gives ticks of about 15.6 µs on a 49 MHz clock. A full-scale constant therefore spans about one second. Constants below 7 are raised to 7 ticks, which gives a floor of about 0.1 ms. A bypass input switches off the automatic retry loop. A saturating 8-bit counter reports how many recovery pulses have been issued since reset. All pins are plain control and status levels, so there is no streaming handshake.

Top module: `frr_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, `tristate_n_o` is 1 and `retry_cnt_o` is 0.
- R2: `fault_n_i` passes through a two-flop synchronizer. With the block idle and `bypass_i` at 0, a fall of `fault_n_i` just before clock edge E0 drives `tristate_n_o` to 0 from edge E0+2.
- R3: Each recovery pulse keeps `tristate_n_o` at 0 for exactly `max(recov_const_i, 7) * PRESCALE` clock cycles. The constant is captured when the pulse starts.
- R4: Any `recov_const_i` value from 0 to 6 gives the same pulse length as a value of 7. A value of 8 gives one tick more.
- R5: After each pulse, `tristate_n_o` stays at 1 for exactly `PRESCALE` cycles. If the synchronized fault is still low at that point, the next pulse starts at once.
- R6: If the fault clears, no further pulse starts. A pulse already in progress still runs its full length.
- R7: While `bypass_i` is 1, `tristate_n_o` is 1 from the next clock edge on. This aborts a pulse in progress, and no pulse starts, whatever the fault line does.
- R8: `retry_cnt_o` rises by exactly 1 at the start of each pulse and saturates at 255. Reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_n_i | input | 1 | Asynchronous fault from the power stage, 0 = fault |
| bypass_i | input | 1 | 1 disables automatic recovery |
| recov_const_i | input | 16 | Hold time in prescaled ticks |
| tristate_n_o | output | 1 | Recovery request to the power stage, 0 = hold in recovery |
| retry_cnt_o | output | 8 | Saturating count of recovery pulses |

## Verification
The first pattern is a fault held across several periods. It shows whether the sequencer loops with the exact low and high run lengths. It also shows the synchronizer latency on the first pulse. Single faults with constants of 0, 6, 7 and 8 show where the clamp sits. A fault that clears partway through a hold checks that the pulse still completes and that no retry follows. Bypass is tried two ways: raised during a hold, which must abort it, and held with the fault asserted, which must start nothing. A long fault of 260 pulses shows whether the counter saturates or wraps.

// File: rtl/frr_pkg.sv
package frr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_GAP  = 2'd2
  } frr_state_e;
endpackage

// File: rtl/frr_sync.sv
module frr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/frr_tick.sv
module frr_tick #(
  parameter int PRESCALE = 768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clr_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/frr_hold_timer.sv
module frr_hold_timer #(
  parameter int CONST_W   = 16,
  parameter int MIN_TICKS = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [CONST_W-1:0] const_i,
  input  logic               run_i,
  input  logic               tick_i,
  output logic               done_o
);
  localparam logic [CONST_W-1:0] FLOOR = CONST_W'(MIN_TICKS);

  logic [CONST_W-1:0] left_q;
  logic [CONST_W-1:0] load_val;

  assign load_val = (const_i < FLOOR) ? FLOOR : const_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              left_q <= '0;
    else if (load_i)                         left_q <= load_val;
    else if (run_i && tick_i && left_q != 0) left_q <= left_q - 1'b1;
  end

  assign done_o = run_i && tick_i && (left_q == CONST_W'(1));
endmodule

// File: rtl/frr_retry_ctr.sv
module frr_retry_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     count_o <= '0;
    else if (inc_i && ~&count_o)    count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/frr_seq.sv
module frr_seq #(
  parameter int PRESCALE    = 768,
  parameter int CONST_W     = 16,
  parameter int MIN_TICKS   = 7,
  parameter int RETRY_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fault_n_i,
  input  logic               bypass_i,
  input  logic [CONST_W-1:0] recov_const_i,
  output logic               tristate_n_o,
  output logic [RETRY_W-1:0] retry_cnt_o
);
  import frr_pkg::*;

  frr_state_e state_q, state_d;
  logic fault_n_s, tick, hold_done, enter_hold, enter_gap;

  frr_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(fault_n_i), .q_o(fault_n_s)
  );

  frr_tick #(.PRESCALE(PRESCALE)) tick_i (
    .clk(clk), .rst_n(rst_n), .clr_i(enter_hold || enter_gap), .tick_o(tick)
  );

  frr_hold_timer #(.CONST_W(CONST_W), .MIN_TICKS(MIN_TICKS)) timer_i (
    .clk(clk), .rst_n(rst_n), .load_i(enter_hold), .const_i(recov_const_i),
    .run_i(state_q == ST_HOLD), .tick_i(tick), .done_o(hold_done)
  );

  frr_retry_ctr #(.W(RETRY_W)) retry_i (
    .clk(clk), .rst_n(rst_n), .inc_i(enter_hold), .count_o(retry_cnt_o)
  );

  always_comb begin
    state_d = state_q;
    if (bypass_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (!fault_n_s) state_d = ST_HOLD;
        ST_HOLD: if (hold_done)  state_d = ST_GAP;
        ST_GAP:  if (tick)       state_d = fault_n_s ? ST_IDLE : ST_HOLD;
        default:                 state_d = ST_IDLE;
      endcase
    end
  end

  assign enter_hold = (state_d == ST_HOLD) && (state_q != ST_HOLD);
  assign enter_gap  = (state_d == ST_GAP)  && (state_q != ST_GAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      tristate_n_o <= 1'b1;
    end else begin
      state_q      <= state_d;
      tristate_n_o <= (state_d != ST_HOLD);
    end
  end
endmodule

// File: rtl/frr_seq_chk.sv
module frr_seq_chk #(
  parameter int PRESCALE  = 768,
  parameter int MIN_TICKS = 7,
  parameter int RETRY_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bypass_i,
  input logic               tristate_n_o,
  input logic [RETRY_W-1:0] retry_cnt_o
);
  logic [31:0] low_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            low_run_q <= '0;
    else if (!tristate_n_o) low_run_q <= low_run_q + 1;
    else                   low_run_q <= '0;
  end

  p_bypass_forces_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_i |=> tristate_n_o);

  p_no_pulse_when_bypassed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tristate_n_o) |-> !$past(bypass_i));

  p_min_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tristate_n_o) && !$past(bypass_i)) |-> (low_run_q >= 32'(MIN_TICKS * PRESCALE)));

  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_cnt_o != $past(retry_cnt_o)) |-> (retry_cnt_o == RETRY_W'($past(retry_cnt_o) + 1'b1)));

  p_count_saturates_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (&retry_cnt_o) |=> (&retry_cnt_o));

  p_pulse_counted_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tristate_n_o) |-> ((retry_cnt_o != $past(retry_cnt_o)) || (&retry_cnt_o)));
endmodule

bind frr_seq frr_seq_chk #(
  .PRESCALE(PRESCALE), .MIN_TICKS(MIN_TICKS), .RETRY_W(RETRY_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bypass_i(bypass_i),
  .tristate_n_o(tristate_n_o), .retry_cnt_o(retry_cnt_o)
);

// File: tb/frr_seq_tb.sv
module frr_seq_tb_top;
  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fault_n = 1'b1;
  logic        bypass = 1'b0;
  logic [15:0] rc = 16'd10;
  logic        tristate_n;
  logic [7:0]  retry_cnt;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_q[$];
  int run = 0;

  always #2 clk = ~clk;

  frr_seq #(.PRESCALE(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .fault_n_i(fault_n), .bypass_i(bypass),
    .recov_const_i(rc), .tristate_n_o(tristate_n), .retry_cnt_o(retry_cnt)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: measures every low pulse and compares it with the scoreboard queue
  always @(negedge clk) begin
    if (!rst_n) run = 0;
    else if (!tristate_n) run++;
    else if (run > 0) begin
      if (exp_q.size() == 0) check("R3 unexpected pulse length", run, 0);
      else check("R3 pulse length", run, exp_q.pop_front());
      run = 0;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; fault_n = 1'b1; bypass = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
  endtask

  task automatic single_pulse(input int cval, input int exp_len, input string req);
    do_reset();
    rc = 16'(cval);
    exp_q.push_back(exp_len);
    fault_n = 1'b0;
    @(posedge tristate_n);
    @(negedge clk);
    fault_n = 1'b1;
    wait_n(40);
    check(req, retry_cnt, 1);
    check("R6 idle after fault cleared", tristate_n, 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check("watchdog expired", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : driver
    int gap;
    // R1: reset state
    wait_n(2);
    check("R1 tristate in reset", tristate_n, 1);
    check("R1 retry count in reset", retry_cnt, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 tristate after reset", tristate_n, 1);
    check("R1 retry after reset", retry_cnt, 0);

    // R2/R3/R5: persistent fault, three pulses
    rc = 16'd10;
    repeat (3) exp_q.push_back(10 * P);
    fault_n = 1'b0;
    @(negedge clk); check("R2 still high after E0", tristate_n, 1);
    @(negedge clk); check("R2 still high after E1", tristate_n, 1);
    @(negedge clk); check("R2 low after E2", tristate_n, 0);
    @(posedge tristate_n);
    @(negedge clk);
    gap = 0;
    while (tristate_n) begin gap++; @(negedge clk); end
    check("R5 gap length", gap, P);
    @(posedge tristate_n);
    @(posedge tristate_n);
    @(negedge clk);
    fault_n = 1'b1;
    wait_n(100);
    check("R6 no pulse after clear", tristate_n, 1);
    check("R8 retry count three", retry_cnt, 3);

    // R4: clamp boundary
    single_pulse(0, 7 * P, "R4 const 0 retry");
    single_pulse(6, 7 * P, "R4 const 6 retry");
    single_pulse(7, 7 * P, "R4 const 7 retry");
    single_pulse(8, 8 * P, "R4 const 8 retry");

    // R6: fault clears mid-hold, pulse completes
    do_reset();
    rc = 16'd10;
    exp_q.push_back(10 * P);
    fault_n = 1'b0;
    @(negedge clk);
    while (tristate_n) @(negedge clk);
    wait_n(5);
    fault_n = 1'b1;
    @(posedge tristate_n);
    wait_n(60);
    check("R6 single retry", retry_cnt, 1);
    check("R6 stays released", tristate_n, 1);

    // R7: bypass aborts a hold, then blocks pulses
    do_reset();
    rc = 16'd50;
    exp_q.push_back(21);
    fault_n = 1'b0;
    @(negedge clk);
    while (tristate_n) @(negedge clk);
    wait_n(20);
    bypass = 1'b1;
    @(negedge clk);
    check("R7 abort on bypass", tristate_n, 1);
    begin
      int lows = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (!tristate_n) lows++;
      end
      check("R7 no low while bypassed", lows, 0);
    end
    check("R7 retry unchanged", retry_cnt, 1);
    fault_n = 1'b1;
    wait_n(5);
    bypass = 1'b0;
    wait_n(20);
    check("R7 quiet after bypass off", tristate_n, 1);

    // R7: bypass held from reset with fault asserted
    do_reset();
    bypass = 1'b1;
    fault_n = 1'b0;
    wait_n(300);
    check("R7 bypassed no start", tristate_n, 1);
    check("R7 bypassed count zero", retry_cnt, 0);
    fault_n = 1'b1;
    wait_n(5);
    bypass = 1'b0;

    // R8: saturation
    do_reset();
    rc = 16'd0;
    fault_n = 1'b0;
    for (int i = 0; i < 260; i++) begin
      exp_q.push_back(7 * P);
      @(posedge tristate_n);
      if (i == 254) begin
        @(negedge clk);
        check("R8 count at 255", retry_cnt, 255);
      end
    end
    @(negedge clk);
    fault_n = 1'b1;
    wait_n(40);
    check("R8 saturated count", retry_cnt, 255);

    // R8: reset clears
    do_reset();
    @(negedge clk);
    check("R8 reset clears count", retry_cnt, 0);
    check("R3 scoreboard drained", exp_q.size(), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule